// File: doc/BRIEF.md
# Per-Sample Complex Phase Corrector

This block rotates a stream of complex baseband samples belonging to one radar pulse. Each accepted sample is multiplied by a complex coefficient pair (cosine, sine) fetched from a small programmable table. The table address is the position of the sample inside its pulse, and that position returns to zero on every start-of-pulse marker. One instance is placed in front of the forward transform of the received channel and another in front of the reference channel.

The stream takes one complex sample per clock. A start marker opens a pulse and latches the selected pulse length. Samples that arrive with no pulse open are discarded. The product is rounded, saturated and delivered after a fixed three-stage pipeline, and the valid and start markers travel with the data. The coefficient table is written through a simple write port, and only while no pulse is open. A write at any other time is dropped and raises a sticky error flag.

The table depth is a parameter (2^TBL_AW entries, 64 by default). The three length choices are a quarter, a half and all of that depth. A build for 16K, 32K or 64K-sample pulses therefore sets TBL_AW to 16.

Top module: `phase_rotator`

## Requirements
- R1: While rst_n is low, out_valid, out_start and wr_err read 0.
- R2: For input (a + jb) and table entry (c, d), with all values signed, out_i = round((a*c - b*d) / 2^13) and out_q = round((a*d + b*c) / 2^13). Rounding goes to the nearest integer, and ties round toward plus infinity: the result is floor((x + 4096) / 8192).
- R3: A rounded result above 511 is output as 511. A rounded result below -512 is output as -512.
- R4: A sample accepted with in_start high uses table entry 0. Each following accepted sample of the same pulse uses the next entry. A new in_start restarts at entry 0 even in the middle of a pulse.
- R5: len_sel is sampled on the start sample. The code 0 selects DEPTH/4 samples, the code 1 selects DEPTH/2, and the codes 2 and 3 select DEPTH. Once that many samples have been accepted the pulse closes. A valid sample without in_start while no pulse is open produces no output. A change of len_sel inside a pulse has no effect on that pulse.
- R6: A sample accepted at clock edge n appears on the outputs after edge n+2. Cycles where in_valid is low give gaps in out_valid, and each accepted sample yields exactly one output.
- R7: A write (wr_en high) while no pulse is open and no start sample is present updates entry wr_addr. Samples accepted from the next cycle onward see the new value.
- R8: A write during an open pulse, or in the cycle of a start sample, leaves the table unchanged and sets wr_err from the next cycle. wr_err stays set until reset.
- R9: out_start is high exactly on the output of a start sample, and only together with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Input sample present |
| in_start | input | 1 | Input sample is the first of a pulse |
| in_i | input | 8 | Input real part, signed |
| in_q | input | 8 | Input imaginary part, signed |
| len_sel | input | 2 | Pulse length code, sampled on the start sample |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Table entry to write |
| wr_cos | input | 16 | Cosine value, signed, scale 2^15 |
| wr_sin | input | 16 | Sine value, signed, scale 2^15 |
| out_valid | output | 1 | Output sample present |
| out_start | output | 1 | Output sample is the first of a pulse |
| out_i | output | 10 | Rotated real part, signed, two fraction bits |
| out_q | output | 10 | Rotated imaginary part, signed, two fraction bits |
| wr_err | output | 1 | Sticky flag for a rejected table write |

## Verification
The bench loads a table with a distinct value in every entry. That way a sample counter that is off by one, or fails to restart on a second start marker, shows up as wrong output data rather than passing unseen. Pulses are sent with gaps in valid, with samples after the pulse has closed, and with len_sel changed in the middle of a pulse. A design that counted idle cycles, let a trailing sample through, or looked at len_sel live would give a wrong value, an extra output or a missing one. Directed cases cover rounding ties at plus and minus one half and both saturation limits, which expose truncation or wraparound. Writes during a pulse and on a start cycle are checked in two ways: the later output data must show the old coefficient, and the flag must rise and stay set until reset.

// File: rtl/phase_corr_pkg.sv
package phase_corr_pkg;

  // Pulse length code, sampled on the start sample.
  typedef enum logic [1:0] {
    LEN_QUARTER  = 2'd0,
    LEN_HALF     = 2'd1,
    LEN_FULL     = 2'd2,
    LEN_FULL_ALT = 2'd3
  } len_code_e;

endpackage

// File: rtl/phase_idx_ctl.sv
// Sample position counter, pulse window and write gating.
module phase_idx_ctl
  import phase_corr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  len_code_e     len_sel,
  input  logic          wr_en,
  output logic          accept,
  output logic [AW-1:0] idx,
  output logic          wr_ok,
  output logic          wr_err
);

  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST_QTR  = AW'(DEPTH / 4 - 1);
  localparam logic [AW-1:0] LAST_HALF = AW'(DEPTH / 2 - 1);
  localparam logic [AW-1:0] LAST_FULL = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  len_code_e     len_q, len_d;
  logic          err_q, err_d;
  logic [AW-1:0] last;
  logic          busy;

  always_comb begin
    accept = in_valid & (in_start | act_q);
    idx    = in_start ? '0 : cnt_q;
    len_d  = (in_valid & in_start) ? len_sel : len_q;
    case (len_d)
      LEN_QUARTER: last = LAST_QTR;
      LEN_HALF:    last = LAST_HALF;
      default:     last = LAST_FULL;
    endcase
    cnt_d = cnt_q;
    act_d = act_q;
    if (accept) begin
      cnt_d = idx + 1'b1;
      act_d = (idx != last);
    end
    busy  = act_q | (in_valid & in_start);
    wr_ok = wr_en & ~busy;
    err_d = err_q | (wr_en & busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      len_q <= LEN_FULL;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      len_q <= len_d;
      err_q <= err_d;
    end
  end

  assign wr_err = err_q;

endmodule

// File: rtl/phase_coef_table.sv
// Coefficient storage: one write port, one combinational read port.
module phase_coef_table #(
  parameter int AW     = 6,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic signed [COEF_W-1:0] wcos,
  input  logic signed [COEF_W-1:0] wsin,
  input  logic [AW-1:0]            raddr,
  output logic signed [COEF_W-1:0] rcos,
  output logic signed [COEF_W-1:0] rsin
);

  localparam int DEPTH = 1 << AW;

  logic signed [COEF_W-1:0] cos_mem [DEPTH];
  logic signed [COEF_W-1:0] sin_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cos_mem[waddr] <= wcos;
      sin_mem[waddr] <= wsin;
    end
  end

  assign rcos = cos_mem[raddr];
  assign rsin = sin_mem[raddr];

endmodule

// File: rtl/phase_cmul.sv
// Two-stage complex multiply with round-to-nearest and saturation.
module phase_cmul #(
  parameter int IN_W   = 8,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 10,
  parameter int SHIFT  = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_in,
  input  logic                     s_in,
  input  logic signed [IN_W-1:0]   a,
  input  logic signed [IN_W-1:0]   b,
  input  logic signed [COEF_W-1:0] c,
  input  logic signed [COEF_W-1:0] d,
  output logic                     v_out,
  output logic                     s_out,
  output logic signed [OUT_W-1:0]  re_o,
  output logic signed [OUT_W-1:0]  im_o
);

  localparam int PROD_W = IN_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int RND_W  = SUM_W + 1;
  localparam logic signed [RND_W-1:0] HALF_LSB = RND_W'(longint'(1) << (SHIFT - 1));
  localparam logic signed [RND_W-1:0] MAXV = RND_W'((longint'(1) << (OUT_W - 1)) - 1);
  localparam logic signed [RND_W-1:0] MINV = RND_W'(-(longint'(1) << (OUT_W - 1)));

  logic signed [PROD_W-1:0] ac_q, bd_q, ad_q, bc_q;
  logic                     v2_q, s2_q, v3_q, s3_q;
  logic signed [SUM_W-1:0]  re_sum, im_sum;
  logic signed [OUT_W-1:0]  re_d, im_d, re_q, im_q;

  function automatic logic signed [OUT_W-1:0] rnd_sat(input logic signed [SUM_W-1:0] x);
    logic signed [RND_W-1:0] t;
    t = (RND_W'(x) + HALF_LSB) >>> SHIFT;
    if (t > MAXV)      return OUT_W'(MAXV);
    else if (t < MINV) return OUT_W'(MINV);
    else               return OUT_W'(t);
  endfunction

  always_comb begin
    re_sum = SUM_W'(ac_q) - SUM_W'(bd_q);
    im_sum = SUM_W'(ad_q) + SUM_W'(bc_q);
    re_d   = rnd_sat(re_sum);
    im_d   = rnd_sat(im_sum);
  end

  // Datapath registers load only with a valid sample.
  always_ff @(posedge clk) begin
    if (v_in) begin
      ac_q <= a * c;
      bd_q <= b * d;
      ad_q <= a * d;
      bc_q <= b * c;
    end
    if (v2_q) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q <= 1'b0;
      s2_q <= 1'b0;
      v3_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      v2_q <= v_in;
      s2_q <= v_in & s_in;
      v3_q <= v2_q;
      s3_q <= v2_q & s2_q;
    end
  end

  assign v_out = v3_q;
  assign s_out = s3_q;
  assign re_o  = re_q;
  assign im_o  = im_q;

endmodule

// File: rtl/phase_rotator.sv
// Per-sample complex phase corrector, top level.
module phase_rotator
  import phase_corr_pkg::*;
#(
  parameter int IN_W   = 8,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 10,
  parameter int SHIFT  = 13,
  parameter int TBL_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [IN_W-1:0]   in_i,
  input  logic [IN_W-1:0]   in_q,
  input  logic [1:0]        len_sel,
  input  logic              wr_en,
  input  logic [TBL_AW-1:0] wr_addr,
  input  logic [COEF_W-1:0] wr_cos,
  input  logic [COEF_W-1:0] wr_sin,
  output logic              out_valid,
  output logic              out_start,
  output logic [OUT_W-1:0]  out_i,
  output logic [OUT_W-1:0]  out_q,
  output logic              wr_err
);

  logic                     accept, wr_ok;
  logic [TBL_AW-1:0]        idx;
  logic signed [COEF_W-1:0] rd_cos, rd_sin;
  logic signed [IN_W-1:0]   a_q, b_q;
  logic signed [COEF_W-1:0] c_q, d_q;
  logic                     v1_q, s1_q;
  logic signed [OUT_W-1:0]  re_w, im_w;

  phase_idx_ctl #(.AW(TBL_AW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .len_sel  (len_code_e'(len_sel)),
    .wr_en    (wr_en),
    .accept   (accept),
    .idx      (idx),
    .wr_ok    (wr_ok),
    .wr_err   (wr_err)
  );

  phase_coef_table #(.AW(TBL_AW), .COEF_W(COEF_W)) u_tbl (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_addr),
    .wcos  (wr_cos),
    .wsin  (wr_sin),
    .raddr (idx),
    .rcos  (rd_cos),
    .rsin  (rd_sin)
  );

  // Stage 1: capture sample and its coefficient.
  always_ff @(posedge clk) begin
    if (accept) begin
      a_q <= in_i;
      b_q <= in_q;
      c_q <= rd_cos;
      d_q <= rd_sin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      v1_q <= accept;
      s1_q <= accept & in_start;
    end
  end

  phase_cmul #(.IN_W(IN_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .v_in  (v1_q),
    .s_in  (s1_q),
    .a     (a_q),
    .b     (b_q),
    .c     (c_q),
    .d     (d_q),
    .v_out (out_valid),
    .s_out (out_start),
    .re_o  (re_w),
    .im_o  (im_w)
  );

  assign out_i = re_w;
  assign out_q = im_w;

endmodule

// File: rtl/phase_rotator_chk.sv
module phase_rotator_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_start,
  input logic wr_en,
  input logic out_valid,
  input logic out_start,
  input logic wr_err
);

  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen_q <= 2'd0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_start && !wr_err));

  assert_start_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);

  assert_busy_write_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_valid && in_start) |=> wr_err);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  assert_start_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd3 && $past(in_valid && in_start, 3)) |-> out_start);

  assert_no_output_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd3 && !$past(in_valid, 3)) |-> !out_valid);

endmodule

bind phase_rotator phase_rotator_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_start  (in_start),
  .wr_en     (wr_en),
  .out_valid (out_valid),
  .out_start (out_start),
  .wr_err    (wr_err)
);

// File: tb/phase_rotator_bench.sv
module phase_rotator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_start, wr_en;
  logic [7:0]  in_i, in_q;
  logic [1:0]  len_sel;
  logic [5:0]  wr_addr;
  logic [15:0] wr_cos, wr_sin;
  logic        out_valid, out_start, wr_err;
  logic [9:0]  out_i, out_q;

  int nchecks = 0;
  int nerrors = 0;
  int cyc = 0;

  int m_tc [DEPTH];
  int m_ts [DEPTH];
  int m_cnt = 0;
  int m_len = DEPTH;
  bit m_active = 0;

  int    q_due [$];
  int    q_i   [$];
  int    q_q   [$];
  bit    q_s   [$];
  string q_tag [$];

  phase_rotator u_phase_rotator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_i(in_i), .in_q(in_q), .len_sel(len_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_cos(wr_cos), .wr_sin(wr_sin),
    .out_valid(out_valid), .out_start(out_start), .out_i(out_i),
    .out_q(out_q), .wr_err(wr_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd_sat(longint p);
    longint r;
    r = (p + 4096) >>> 13;
    if (r > 511)  r = 511;
    if (r < -512) r = -512;
    return int'(r);
  endfunction

  function automatic int len_of(logic [1:0] code);
    case (code)
      2'd0:    return DEPTH / 4;
      2'd1:    return DEPTH / 2;
      default: return DEPTH;
    endcase
  endfunction

  // Output monitor: every output is matched to the model in order and in time.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (q_due.size() == 0) begin
            check(0, "R5", "unexpected output sample", 1, 0);
          end else begin
            check(q_due[0] == cyc, "R6", "output cycle", cyc, q_due[0]);
            check(int'($signed(out_i)) == q_i[0], q_tag[0], "out_i", int'($signed(out_i)), q_i[0]);
            check(int'($signed(out_q)) == q_q[0], q_tag[0], "out_q", int'($signed(out_q)), q_q[0]);
            check(out_start == q_s[0], "R9", "out_start", int'(out_start), int'(q_s[0]));
            void'(q_due.pop_front()); void'(q_i.pop_front()); void'(q_q.pop_front());
            void'(q_s.pop_front()); void'(q_tag.pop_front());
          end
        end else if (q_due.size() > 0 && q_due[0] <= cyc) begin
          check(0, "R6", "missing output sample", 0, 1);
          void'(q_due.pop_front()); void'(q_i.pop_front()); void'(q_q.pop_front());
          void'(q_s.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "R6", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

  // Drive one cycle of stream input, updating the model.
  task automatic drive(bit v, bit s, int i, int q, string tag);
    int k;
    in_valid = v; in_start = s; in_i = 8'(i); in_q = 8'(q);
    if (v && (s || m_active)) begin
      k = s ? 0 : m_cnt;
      if (s) m_len = len_of(len_sel);
      q_due.push_back(cyc + 3);
      q_i.push_back(rnd_sat(longint'(i) * m_tc[k] - longint'(q) * m_ts[k]));
      q_q.push_back(rnd_sat(longint'(i) * m_ts[k] + longint'(q) * m_tc[k]));
      q_s.push_back(s);
      q_tag.push_back(tag);
      m_cnt = k + 1;
      m_active = (m_cnt != m_len);
    end
    @(negedge clk);
    in_valid = 0; in_start = 0;
  endtask

  task automatic wr(int addr, int c, int s);
    wr_en = 1; wr_addr = 6'(addr); wr_cos = 16'(c); wr_sin = 16'(s);
    if (!m_active) begin m_tc[addr] = c; m_ts[addr] = s; end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_pulse(string tag);
    while (m_active) drive(1, 0, 3, -5, tag);
  endtask

  task automatic drain(string tag);
    repeat (6) @(negedge clk);
    check(q_due.size() == 0, tag, "outputs left pending", q_due.size(), 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_active = 0; m_cnt = 0;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_start == 0, "R1", "out_start in reset", int'(out_start), 0);
    check(wr_err == 0, "R1", "wr_err in reset", int'(wr_err), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_load_table();
    for (int k = 0; k < DEPTH; k++) wr(k, 20000 - k * 600, k * 450 - 14000);
    check(wr_err == 0, "R7", "idle writes flag", int'(wr_err), 0);
  endtask

  task automatic t_basic_pulse();
    len_sel = 2'd0;
    drive(1, 1, 100, -50, "R2_R4");
    for (int k = 1; k < DEPTH / 4; k++) drive(1, 0, (k * 37) % 256 - 128, 90 - k * 11, "R2_R4");
    drain("R4");
  endtask

  task automatic t_gaps_and_tail();
    len_sel = 2'd1;
    drive(1, 1, -7, 120, "R6");
    for (int k = 1; k < DEPTH / 2; k++) begin
      drive(1, 0, 127 - k * 8, -128 + k * 7, "R6");
      if (k % 3 == 0) drive(0, 0, 55, 55, "R6");
    end
    drive(1, 0, 11, 22, "R5");
    drive(1, 0, 33, 44, "R5");
    drain("R5");
  endtask

  task automatic t_restart();
    len_sel = 2'd0;
    drive(1, 1, 40, 40, "R4");
    for (int k = 1; k < 6; k++) drive(1, 0, k * 10, -k * 9, "R4");
    drive(1, 1, -90, 17, "R4");
    for (int k = 1; k < 5; k++) drive(1, 0, -k * 13, k * 21, "R4");
    finish_pulse("R4");
    drain("R4");
  endtask

  task automatic t_round_sat();
    wr(0, 32767, -32767);
    wr(1, 4096, 0);
    wr(2, 4096, 0);
    wr(3, -32768, 32767);
    len_sel = 2'd0;
    drive(1, 1, 127, 127, "R3");
    drive(1, 0, 1, 0, "R2");
    drive(1, 0, -1, 0, "R2");
    drive(1, 0, 127, 127, "R3");
    finish_pulse("R3");
    drain("R3");
  endtask

  task automatic t_len_latch();
    len_sel = 2'd1;
    drive(1, 1, 60, -60, "R5");
    drive(1, 0, 61, -61, "R5");
    len_sel = 2'd0;
    for (int k = 2; k < DEPTH / 2; k++) drive(1, 0, k, -k, "R5");
    check(m_active == 0, "R5", "model pulse closed", int'(m_active), 0);
    drive(1, 0, 9, 9, "R5");
    len_sel = 2'd3;
    drive(1, 1, 5, 6, "R5");
    finish_pulse("R5");
    drain("R5");
  endtask

  task automatic t_busy_writes();
    // write in the same cycle as a start sample
    len_sel = 2'd0;
    wr_en = 1; wr_addr = 6'd0; wr_cos = 16'd1000; wr_sin = 16'd1000;
    drive(1, 1, 100, 100, "R8");
    wr_en = 0;
    check(wr_err == 1, "R8", "flag after start-cycle write", int'(wr_err), 1);
    finish_pulse("R8");
    drain("R8");
    len_sel = 2'd0;
    drive(1, 1, 100, 100, "R8");
    finish_pulse("R8");
    drain("R8");
    check(wr_err == 1, "R8", "flag still set", int'(wr_err), 1);
    do_reset();
    // write in an idle gap of an open pulse
    len_sel = 2'd0;
    drive(1, 1, 20, 30, "R8");
    for (int k = 1; k < 4; k++) drive(1, 0, k, k, "R8");
    wr(5, -30000, 30000);
    check(wr_err == 1, "R8", "flag after mid-pulse write", int'(wr_err), 1);
    finish_pulse("R8");
    drain("R8");
    // idle write still works, and a later pulse sees it while the old entry 5 remains
    wr(6, 12345, -2345);
    check(wr_err == 1, "R8", "flag sticky after idle write", int'(wr_err), 1);
    drive(1, 1, 1, 1, "R7");
    for (int k = 1; k < DEPTH / 4; k++) drive(1, 0, 120 - k, k - 100, "R7");
    drain("R7");
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_start = 0; in_i = 0; in_q = 0;
    len_sel = 0; wr_en = 0; wr_addr = 0; wr_cos = 0; wr_sin = 0;
    @(negedge clk);
    do_reset();
    t_load_table();
    t_basic_pulse();
    t_gaps_and_tail();
    t_restart();
    t_round_sat();
    t_len_latch();
    t_busy_writes();
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

endmodule